// File: doc/BRIEF.md
# Multi-Policy Float-to-Integer Converter

This block turns a 64-bit binary floating-point operand (a double, or a single value already widened to double format) into a signed or unsigned integer of 32 or 64 bits. A 3-bit mode input picks two things. The first is whether the rounding direction comes from the caller's rounding-control input or is forced to truncation. The second is which of three out-of-range policies applies: clamp to the limits with NaN giving the most negative integer, clamp to the limits with NaN giving zero, or wrap modulo 2^N with NaN and both infinities giving zero.

Besides the integer, the block reports whether the conversion lost the operand's exact numeric value, as an integer overflow. It also produces a summary-overflow bit and a four-bit condition field that compares the result with zero. The operation is pipelined in two register stages and accepts a new operand every cycle.

Top module: `fp_to_int_cvt`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is 0.
- R2: When `in_mode[0]` is 1 the rounding is toward zero. Otherwise `in_rm` selects it: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: For modes 000 and 001, a NaN gives the minimum integer of the selected type. An out-of-range value gives the minimum if negative and the maximum if positive. Any other value gives its rounded value.
- R4: For modes 010 and 011, the behaviour is the same as R3, except that a NaN gives 0.
- R5: For modes 100 and 101, a NaN or either infinity gives 0. Any other value is rounded, reduced modulo 2^N, and its low N bits are read as the signed or unsigned result. This holds for exponents far above N.
- R6: Modes 110 and 111 set `out_illegal`. In that case `out_result`, `out_ov` and `out_cr` are 0, and `out_so` equals the `in_so` that came with the operand.
- R7: `in_wide`=1 selects N=64 and `in_wide`=0 selects N=32. The signed limits are -2^(N-1) and 2^(N-1)-1, and the unsigned limits are 0 and 2^N-1. A 32-bit signed result is sign-extended to 64 bits, and a 32-bit unsigned result is zero-extended.
- R8: With `in_oe`=1, `out_ov` is 1 exactly when the result does not equal the operand's numeric value: the operand was inexact, NaN, infinite, or out of range. With `in_oe`=0, `out_ov` is 0. `out_so` is `in_so` OR `out_ov`.
- R9: With `in_rc`=1, `out_cr` is {lt, gt, eq, so} (bit 3 down to bit 0). These compare the result with zero, signed for signed types and unsigned for unsigned types, and bit 0 is `out_so`. With `in_rc`=0, `out_cr` is 0.
- R10: The outputs for an operand appear exactly two clock edges after it is sampled with `in_valid`=1, and `out_valid` is 1 in that cycle. Every output is 0 in a cycle whose operand had `in_valid`=0.
- R11: Zero and subnormal operands give 0, except that a subnormal gives +1 when rounding toward +infinity and is positive. When rounding toward -infinity and negative, it gives -1 for signed types and 0 (out of range) for unsigned types. A subnormal is always inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_fp | input | 64 | Double-format operand bits |
| in_mode | input | 3 | Rounding source and out-of-range policy |
| in_rm | input | 2 | Rounding direction from the control register |
| in_signed | input | 1 | 1 for a signed result type |
| in_wide | input | 1 | 1 for a 64-bit result, 0 for 32-bit |
| in_oe | input | 1 | Enable overflow reporting |
| in_rc | input | 1 | Enable the condition field |
| in_so | input | 1 | Incoming summary-overflow state |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Integer result, extended to 64 bits |
| out_ov | output | 1 | Value was not preserved exactly |
| out_so | output | 1 | Updated summary overflow |
| out_cr | output | 4 | {lt, gt, eq, so} |
| out_illegal | output | 1 | Reserved mode was requested |

## Verification
Every result, flag and the valid bit belong to the operand driven two clock edges earlier. No output depends on when inside that window it is examined. The bench drives a new operand, or an idle cycle, at each falling edge and pushes the model's prediction into a queue. Once the queue holds two entries, it pops the oldest at the next falling edge and compares it with the ports. Each prediction is therefore matched to the output registers exactly two rising edges after its operand was sampled. Idle cycles are mixed into the stream, so the all-zero outputs of an empty slot are checked as well.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int BIAS   = 1023;
    localparam int INT_W  = 64;
    localparam int HALF_W = INT_W / 2;
    localparam int FIX_W  = 2 * INT_W;
    localparam int MODE_W = 3;
    localparam int CR_W   = 4;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rnd_e;

    typedef enum logic [1:0] {
        POL_SAT_MIN  = 2'b00,
        POL_SAT_ZERO = 2'b01,
        POL_WRAP     = 2'b10,
        POL_NONE     = 2'b11
    } pol_e;

    // Magnitude after rounding, plus the classification needed downstream.
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_inf;
        logic             huge;       // magnitude at or above 2^INT_W
        logic             inexact;
        logic [INT_W:0]   mag;
        logic [INT_W-1:0] wrap_bits;  // magnitude modulo 2^INT_W
    } mag_t;

    typedef struct packed {
        logic is_signed;
        logic wide;
        logic oe;
        logic rc;
        logic so;
        logic illegal;
        pol_e pol;
    } ctl_t;

    function automatic logic rnd_inc(rnd_e rm, logic neg, logic lsb,
                                     logic rbit, logic sticky);
        case (rm)
            RM_NEAR: return rbit & (sticky | lsb);
            RM_ZERO: return 1'b0;
            RM_UP:   return ~neg & (rbit | sticky);
            default: return neg & (rbit | sticky);
        endcase
    endfunction

endpackage

// File: rtl/fcvt_decode.sv
module fcvt_decode
    import fcvt_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [1:0]        rm_in,
    output pol_e              pol,
    output rnd_e              rm_eff,
    output logic              illegal
);
    always_comb begin
        pol     = pol_e'(mode[MODE_W-1:1]);
        illegal = (pol == POL_NONE);
        rm_eff  = mode[0] ? RM_ZERO : rnd_e'(rm_in);
    end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  logic [FP_W-1:0] fp,
    input  rnd_e            rm,
    output mag_t            mo
);
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr;
    logic [MAN_W:0]   sig;
    int               unb;
    int               sh;
    logic [FIX_W-1:0] fixed;
    logic [INT_W-1:0] ipart;
    logic             rb;
    logic             st;
    logic             inc;

    always_comb begin
        sgn   = fp[FP_W-1];
        ex    = fp[FP_W-2 -: EXP_W];
        fr    = fp[MAN_W-1:0];
        sig   = {|ex, fr};
        unb   = int'(ex) - BIAS;
        sh    = unb + (INT_W - MAN_W);
        fixed = '0;
        ipart = '0;
        rb    = 1'b0;
        st    = 1'b0;
        mo    = '0;
        mo.sign = sgn;
        if (&ex) begin
            mo.is_nan = |fr;
            mo.is_inf = ~|fr;
            mo.huge   = 1'b1;
        end else if (ex == '0) begin
            st = |fr;
        end else if (unb >= INT_W) begin
            mo.huge = 1'b1;
            if (unb - MAN_W < INT_W)
                mo.wrap_bits = INT_W'(sig) << (unb - MAN_W);
        end else if (sh < 0) begin
            st = 1'b1;
        end else begin
            // binary point sits between bit INT_W and bit INT_W-1
            fixed = FIX_W'(sig) << sh;
            ipart = fixed[FIX_W-1 -: INT_W];
            rb    = fixed[INT_W-1];
            st    = |fixed[INT_W-2:0];
        end
        inc = rnd_inc(rm, sgn, ipart[0], rb, st);
        if (!mo.huge) begin
            mo.mag       = {1'b0, ipart} + (INT_W+1)'(inc);
            mo.inexact   = rb | st;
            mo.wrap_bits = mo.mag[INT_W-1:0];
        end
    end
endmodule

// File: rtl/fcvt_policy.sv
module fcvt_policy
    import fcvt_pkg::*;
(
    input  mag_t             mi,
    input  pol_e             pol,
    input  logic             is_signed,
    input  logic             wide,
    output logic [INT_W-1:0] res,
    output logic             lossy
);
    int               nbits;
    logic [INT_W:0]   pos_lim;
    logic [INT_W:0]   neg_lim;
    logic [INT_W-1:0] max_v;
    logic [INT_W-1:0] min_v;
    logic [INT_W-1:0] in_v;
    logic [INT_W-1:0] wr_v;
    logic             over_pos;
    logic             over_neg;

    always_comb begin
        nbits = wide ? INT_W : HALF_W;
        if (is_signed) begin
            neg_lim = (INT_W+1)'(1) << (nbits - 1);
            pos_lim = neg_lim - (INT_W+1)'(1);
            min_v   = -neg_lim[INT_W-1:0];
        end else begin
            neg_lim = '0;
            pos_lim = ((INT_W+1)'(1) << nbits) - (INT_W+1)'(1);
            min_v   = '0;
        end
        max_v    = pos_lim[INT_W-1:0];
        over_pos = ~mi.sign & (mi.huge | (mi.mag > pos_lim));
        over_neg =  mi.sign & (mi.huge | (mi.mag > neg_lim));
        lossy    = mi.is_nan | mi.is_inf | mi.inexact | over_pos | over_neg;

        in_v = mi.sign ? -mi.mag[INT_W-1:0] : mi.mag[INT_W-1:0];

        wr_v = mi.sign ? -mi.wrap_bits : mi.wrap_bits;
        if (!wide)
            wr_v = is_signed ? {{HALF_W{wr_v[HALF_W-1]}}, wr_v[HALF_W-1:0]}
                             : {{HALF_W{1'b0}}, wr_v[HALF_W-1:0]};

        case (pol)
            POL_SAT_MIN, POL_SAT_ZERO: begin
                if (mi.is_nan)
                    res = (pol == POL_SAT_MIN) ? min_v : '0;
                else if (over_pos)
                    res = max_v;
                else if (over_neg)
                    res = min_v;
                else
                    res = in_v;
            end
            POL_WRAP:
                res = (mi.is_nan | mi.is_inf) ? '0 : wr_v;
            default:
                res = '0;
        endcase
    end
endmodule

// File: rtl/fcvt_flags.sv
module fcvt_flags
    import fcvt_pkg::*;
(
    input  logic [INT_W-1:0] res,
    input  logic             is_signed,
    input  logic             so,
    output logic [CR_W-1:0]  cr
);
    logic lt;
    logic eq;

    always_comb begin
        lt = is_signed & res[INT_W-1];
        eq = (res == '0);
        cr = {lt, ~lt & ~eq, eq, so};
    end
endmodule

// File: rtl/fp_to_int_cvt.sv
module fp_to_int_cvt
    import fcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   in_fp,
    input  logic [MODE_W-1:0] in_mode,
    input  logic [1:0]        in_rm,
    input  logic              in_signed,
    input  logic              in_wide,
    input  logic              in_oe,
    input  logic              in_rc,
    input  logic              in_so,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_ov,
    output logic              out_so,
    output logic [CR_W-1:0]   out_cr,
    output logic              out_illegal
);
    pol_e dec_pol;
    rnd_e dec_rm;
    logic dec_ill;
    mag_t rnd_mag;

    fcvt_decode u_dec (
        .mode    (in_mode),
        .rm_in   (in_rm),
        .pol     (dec_pol),
        .rm_eff  (dec_rm),
        .illegal (dec_ill)
    );

    fcvt_round u_rnd (
        .fp (in_fp),
        .rm (dec_rm),
        .mo (rnd_mag)
    );

    // stage 1: classified, rounded magnitude
    logic s1_valid;
    ctl_t s1_ctl;
    mag_t s1_mag;

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            s1_valid <= 1'b0;
            s1_ctl   <= '0;
            s1_mag   <= '0;
        end else begin
            s1_valid <= 1'b1;
            s1_ctl   <= '{is_signed: in_signed, wide: in_wide, oe: in_oe,
                          rc: in_rc, so: in_so, illegal: dec_ill, pol: dec_pol};
            s1_mag   <= rnd_mag;
        end
    end

    // stage 2: policy, overflow and condition field
    logic [INT_W-1:0] pol_res;
    logic             lossy;
    logic [INT_W-1:0] res_c;
    logic             ov_c;
    logic             so_c;
    logic [CR_W-1:0]  cr_raw;
    logic [CR_W-1:0]  cr_c;

    fcvt_policy u_pol (
        .mi        (s1_mag),
        .pol       (s1_ctl.pol),
        .is_signed (s1_ctl.is_signed),
        .wide      (s1_ctl.wide),
        .res       (pol_res),
        .lossy     (lossy)
    );

    always_comb begin
        ov_c  = s1_ctl.oe & lossy & ~s1_ctl.illegal;
        so_c  = s1_ctl.so | ov_c;
        res_c = s1_ctl.illegal ? '0 : pol_res;
    end

    fcvt_flags u_flg (
        .res       (res_c),
        .is_signed (s1_ctl.is_signed),
        .so        (so_c),
        .cr        (cr_raw)
    );

    assign cr_c = (s1_ctl.rc & ~s1_ctl.illegal) ? cr_raw : '0;

    always_ff @(posedge clk) begin
        if (rst || !s1_valid) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_ov      <= 1'b0;
            out_so      <= 1'b0;
            out_cr      <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            out_result  <= res_c;
            out_ov      <= ov_c;
            out_so      <= so_c;
            out_cr      <= cr_c;
            out_illegal <= s1_ctl.illegal;
        end
    end
endmodule

// File: rtl/fp_to_int_cvt_chk.sv
module fp_to_int_cvt_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_signed,
    input logic        in_oe,
    input logic        in_rc,
    input logic        in_so,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_ov,
    input logic        out_so,
    input logic [3:0]  out_cr,
    input logic        out_illegal
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R10: valid emerges two edges after the operand
    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6: reserved modes yield no result and no overflow
    assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == 64'd0 && !out_ov && out_cr == 4'd0));

    // R8: overflow needs its enable
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid && !$past(in_oe, 2)) |-> !out_ov);

    // R8: summary overflow covers overflow and the incoming state
    assert_so_cover_R8: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid) |-> (out_so == ($past(in_so, 2) | out_ov)));

    // R9: one comparison flag exactly when enabled
    assert_cr_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid && $past(in_rc, 2) && !out_illegal)
            |-> ($countones(out_cr[3:1]) == 1 && out_cr[0] == out_so));

    // R9: disabled field stays clear; unsigned never negative
    assert_cr_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && out_valid && (!$past(in_rc, 2) || !$past(in_signed, 2)))
            |-> !out_cr[3]);

    // R10: an empty slot leaves every output low
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_result == 64'd0 && !out_ov && !out_so
                        && out_cr == 4'd0 && !out_illegal));
endmodule

bind fp_to_int_cvt fp_to_int_cvt_chk u_chk (.*);

// File: tb/fp_to_int_cvt_tb.sv
`timescale 1ns/1ps
module fp_to_int_cvt_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_fp;
    logic [2:0]  in_mode;
    logic [1:0]  in_rm;
    logic        in_signed, in_wide, in_oe, in_rc, in_so;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_ov, out_so, out_illegal;
    logic [3:0]  out_cr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fp_to_int_cvt u_dut (.*);

    typedef struct {
        logic        v;
        logic [63:0] r;
        logic        ov, so, ill;
        logic [3:0]  cr;
        logic [2:0]  md;
    } exp_t;

    exp_t q[$];

    function automatic string res_tag(logic [2:0] md);
        case (md[2:1])
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk64(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Behavioural model: value = m * 2^ex with arbitrary-precision style integers.
    function automatic exp_t model(logic v, logic [63:0] fp, logic [2:0] md,
                                   logic [1:0] rmi, logic sg, logic wd,
                                   logic oe, logic rc, logic so);
        exp_t e;
        logic s; logic [10:0] ebits; logic [51:0] f;
        logic nan, inf, bigv, exact, up;
        logic [127:0] m, ipart, rem, half, acc;
        logic signed [129:0] val, lo, hi, rr;
        logic [63:0] low;
        logic [1:0] rm;
        int ex, k, n;
        e = '{v: 0, r: 0, ov: 0, so: 0, ill: 0, cr: 0, md: md};
        if (!v) return e;
        e.v = 1;
        if (md[2:1] == 2'b11) begin
            e.ill = 1; e.so = so;
            return e;
        end
        n = wd ? 64 : 32;
        rm = md[0] ? 2'b01 : rmi;
        s = fp[63]; ebits = fp[62:52]; f = fp[51:0];
        nan = (ebits == 11'h7FF) && (f != 0);
        inf = (ebits == 11'h7FF) && (f == 0);
        m = {75'd0, (ebits != 0), f};
        ex = (ebits == 0) ? -1074 : int'(ebits) - 1075;
        bigv = nan || inf;
        exact = 1; acc = m; ipart = 0;
        if (!bigv) begin
            if (ex >= 0) begin
                for (int i = 0; i < ex; i++) acc = acc << 1;
                ipart = acc;
                bigv = (ex > 75);
            end else begin
                k = -ex;
                if (k >= 60) begin
                    ipart = 0; rem = m; half = 128'd1 << 59;
                end else begin
                    ipart = m >> k;
                    rem = m & ((128'd1 << k) - 1);
                    half = 128'd1 << (k - 1);
                end
                exact = (rem == 0);
                case (rm)
                    2'b00: up = (rem > half) || (rem == half && ipart[0]);
                    2'b01: up = 0;
                    2'b10: up = !s && rem != 0;
                    default: up = s && rem != 0;
                endcase
                ipart = ipart + 128'(up);
                acc = ipart;
            end
        end
        val = s ? -$signed({2'b00, ipart}) : $signed({2'b00, ipart});
        if (sg) begin
            lo = -(130'sd1 <<< (n - 1)); hi = (130'sd1 <<< (n - 1)) - 1;
        end else begin
            lo = 0; hi = (130'sd1 <<< n) - 1;
        end
        if (md[2] == 1'b0) begin
            if (nan) rr = md[1] ? 130'sd0 : lo;
            else if (bigv || val > hi || val < lo) rr = s ? lo : hi;
            else rr = val;
            e.r = rr[63:0];
        end else begin
            if (nan || inf) e.r = 0;
            else begin
                low = s ? -acc[63:0] : acc[63:0];
                if (n == 32) low = sg ? {{32{low[31]}}, low[31:0]} : {32'd0, low[31:0]};
                e.r = low;
            end
        end
        e.ov = oe && (nan || inf || !exact || bigv || val > hi || val < lo);
        e.so = so || e.ov;
        if (rc) begin
            if (sg && $signed(e.r) < 0) e.cr = {3'b100, e.so};
            else if (e.r == 0) e.cr = {3'b001, e.so};
            else e.cr = {3'b010, e.so};
        end
        return e;
    endfunction

    task automatic step(logic v, logic [63:0] fp, logic [2:0] md, logic [1:0] rm,
                        logic sg, logic wd, logic oe, logic rc, logic so);
        exp_t e;
        @(negedge clk);
        if (q.size() == 2) begin
            e = q.pop_front();
            chk64("R10", "valid", 64'(out_valid), 64'(e.v));
            chk64(res_tag(e.md), "result", out_result, e.r);
            chk64("R8", "ov", 64'(out_ov), 64'(e.ov));
            chk64("R8", "so", 64'(out_so), 64'(e.so));
            chk64("R9", "cr", 64'(out_cr), 64'(e.cr));
            chk64("R6", "illegal", 64'(out_illegal), 64'(e.ill));
        end
        in_valid = v; in_fp = fp; in_mode = md; in_rm = rm;
        in_signed = sg; in_wide = wd; in_oe = oe; in_rc = rc; in_so = so;
        q.push_back(model(v, fp, md, rm, sg, wd, oe, rc, so));
    endtask

    logic [63:0] vals[32];

    initial begin
        int idx;
        // R2: ties, fractions of both signs; R7: 32/64 limits; R11: zero/subnormal;
        // R5: huge exponents and infinities; R3/R4: NaN and clamping
        vals[0]  = $realtobits(0.0);
        vals[1]  = 64'h8000_0000_0000_0000;
        vals[2]  = $realtobits(1.5);
        vals[3]  = $realtobits(2.5);
        vals[4]  = $realtobits(-2.5);
        vals[5]  = $realtobits(-1.5);
        vals[6]  = $realtobits(0.3);
        vals[7]  = $realtobits(-0.3);
        vals[8]  = $realtobits(0.5);
        vals[9]  = $realtobits(-0.7);
        vals[10] = $realtobits(123456.75);
        vals[11] = $realtobits(-99.5);
        vals[12] = $realtobits(2147483647.5);
        vals[13] = $realtobits(-2147483648.5);
        vals[14] = $realtobits(2147483648.0);
        vals[15] = $realtobits(3000000000.7);
        vals[16] = $realtobits(4294967296.0);
        vals[17] = $realtobits(-4294967297.0);
        vals[18] = $realtobits(9.3e18);
        vals[19] = $realtobits(-9.3e18);
        vals[20] = 64'h43E0_0000_0000_0000;
        vals[21] = 64'h43F0_0000_0000_0000;
        vals[22] = $realtobits(1.0e30);
        vals[23] = 64'h0000_0000_0000_0001;
        vals[24] = 64'h8000_0000_0000_0001;
        vals[25] = 64'h7FF0_0000_0000_0000;
        vals[26] = 64'hFFF0_0000_0000_0000;
        vals[27] = 64'h7FF8_0000_0000_0000;
        vals[28] = $realtobits(1.0e300);
        vals[29] = $realtobits(-123456789012.25);
        vals[30] = $realtobits(-1.0);
        vals[31] = $realtobits(4503599627370497.0);

        rst = 1; in_valid = 0; in_fp = 0; in_mode = 0; in_rm = 0;
        in_signed = 0; in_wide = 0; in_oe = 0; in_rc = 0; in_so = 0;
        repeat (3) @(negedge clk);
        // R1: outputs clear under reset
        chk64("R1", "reset result", out_result, 64'd0);
        chk64("R1", "reset flags", {58'd0, out_valid, out_ov, out_so, out_illegal, out_cr[1:0]} | 64'(out_cr), 64'd0);
        rst = 0;
        @(negedge clk);
        chk64("R1", "after reset valid", 64'(out_valid), 64'd0);

        idx = 0;
        for (int vi = 0; vi < 32; vi++) begin
            for (int md = 0; md < 8; md++) begin
                for (int rm = 0; rm < 4; rm++) begin
                    for (int ty = 0; ty < 4; ty++) begin
                        idx++;
                        if (idx % 7 == 0)
                            step(0, 64'd0, 3'd0, 2'd0, 0, 0, 0, 0, 0);
                        step(1, vals[vi], 3'(md), 2'(rm), ty[0], ty[1],
                             idx[0] ^ idx[3], idx[1] ^ idx[4], idx[2]);
                    end
                end
            end
        end
        repeat (3) step(0, 64'd0, 3'd0, 2'd0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog got=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule